// File: doc/BRIEF.md
# Multi-Stream Sequential Block Prefetcher

The block watches the addresses of second-level cache misses and spots pages that are being read in a streaming pattern. For each tracked 4 KB page it remembers the most recent miss address. When a new miss in the same page falls within a short distance of that address, the block asks memory for the 64-byte block that follows the new miss. Several streams are followed at once, one per page. When every tracking slot is in use, the slot touched longest ago is reused for the new page.

Requests leave through a small first-in first-out queue that has a valid/ready handshake. The miss input has no back-pressure at all. When the queue has no room, a new request is thrown away and a saturating drop counter goes up by one.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, pf_valid is 0, drop_count is 0 and no page is tracked, so a miss to a page seen before the reset issues no request.
- R2: A miss to a page that is not tracked (page = address bits [31:12]) takes a tracking slot and issues no request.
- R3: A miss to a tracked page whose absolute distance from that page's last miss address is less than 256 bytes, in either direction, issues a request for the miss address plus 64. With the queue empty, the request shows on pf_valid/pf_addr in the cycle after the miss is sampled.
- R4: A miss to a tracked page at a distance of 256 bytes or more issues no request. It still becomes the page's last miss address, so a later near miss measured from it does issue a request.
- R5: A near miss in the last 64-byte block of its page (address bits [11:6] all ones) issues no request, so no request ever crosses into another page.
- R6: Eight pages are tracked at most. A miss to a new page while all eight are in use replaces the page whose last miss is oldest, and the replaced page's history is lost: its next miss acts like a first miss.
- R7: Requests are kept in a 4-entry queue and leave in the order they were made. While pf_valid is 1 and pf_ready is 0, pf_valid and pf_addr hold steady.
- R8: A request made while the queue holds 4 entries and nothing leaves in that cycle is discarded, and drop_count goes up by exactly one.
- R9: A request made in the same cycle that the head of a full queue is taken (pf_valid and pf_ready both 1) is accepted, and drop_count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss address is present this cycle |
| miss_addr | input | 32 | Block-aligned miss address |
| pf_valid | output | 1 | Head of the request queue is valid |
| pf_ready | input | 1 | Consumer takes the head this cycle |
| pf_addr | output | 32 | Block address to prefetch |
| drop_count | output | 16 | Saturating count of discarded requests |

## Verification
Two things can happen in the same cycle: a new request tries to enter the queue while the consumer takes the head of that queue. The bench stops the consumer and sends near misses until the queue is full and one request has been discarded. It then issues one more near miss in the same cycle that it raises pf_ready. The check passes when drop_count stays at one and the queue then drains in issue order, ending with the request made in that cycle.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // Outcome of looking up one miss against the stream table
  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_NEW  = 2'd1,
    CLS_NEAR = 2'd2,
    CLS_FAR  = 2'd3
  } miss_cls_e;

  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_ENTRIES    = 8;
  localparam int DEF_PAGE_BITS  = 12;
  localparam int DEF_BLOCK_BITS = 6;
  localparam int DEF_NEAR_LIMIT = 256;
  localparam int DEF_QDEPTH     = 4;
  localparam int DEF_CNT_W      = 16;

endpackage

// File: rtl/spf_tracker.sv
module spf_tracker
  import spf_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int ENTRIES    = DEF_ENTRIES,
  parameter int PAGE_BITS  = DEF_PAGE_BITS,
  parameter int BLOCK_BITS = DEF_BLOCK_BITS,
  parameter int NEAR_LIMIT = DEF_NEAR_LIMIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);

  localparam int TAG_W = ADDR_W - PAGE_BITS;
  localparam int OFF_W = PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int BLK_W = PAGE_BITS - BLOCK_BITS;

  logic             ent_valid [ENTRIES];
  logic [TAG_W-1:0] ent_page  [ENTRIES];
  logic [OFF_W-1:0] ent_last  [ENTRIES];
  logic [IDX_W-1:0] ent_age   [ENTRIES];

  logic [TAG_W-1:0] miss_page;
  logic [OFF_W-1:0] miss_off;
  logic [BLK_W-1:0] miss_blk;
  logic [ENTRIES-1:0] hit_vec;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] lru_idx;
  logic [IDX_W-1:0] tgt_idx;
  logic signed [OFF_W:0] diff;
  logic [OFF_W:0]   mag;
  logic             near;
  logic             at_page_end;
  miss_cls_e        cls;

  assign miss_page   = miss_addr[ADDR_W-1:PAGE_BITS];
  assign miss_off    = miss_addr[PAGE_BITS-1:0];
  assign miss_blk    = miss_addr[PAGE_BITS-1:BLOCK_BITS];
  assign at_page_end = &miss_blk;

  // Parallel tag compare, one comparator per slot
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = ent_valid[g] && (ent_page[g] == miss_page);
    end
  endgenerate

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!ent_valid[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (ent_age[i] == IDX_W'(ENTRIES - 1)) begin
        lru_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    diff = $signed({1'b0, miss_off}) - $signed({1'b0, ent_last[hit_idx]});
    mag  = diff[OFF_W] ? (OFF_W+1)'(-diff) : (OFF_W+1)'(diff);
    near = mag < (OFF_W+1)'(NEAR_LIMIT);
  end

  always_comb begin
    if (!miss_valid)   cls = CLS_IDLE;
    else if (!hit_any) cls = CLS_NEW;
    else if (near)     cls = CLS_NEAR;
    else               cls = CLS_FAR;
  end

  assign tgt_idx   = hit_any ? hit_idx : (free_any ? free_idx : lru_idx);
  assign req_valid = (cls == CLS_NEAR) && !at_page_end;
  assign req_addr  = {miss_addr[ADDR_W-1:BLOCK_BITS] + 1'b1, {BLOCK_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_valid[i] <= 1'b0;
        ent_page[i]  <= '0;
        ent_last[i]  <= '0;
        ent_age[i]   <= IDX_W'(i);
      end
    end else if (cls != CLS_IDLE) begin
      ent_valid[tgt_idx] <= 1'b1;
      ent_page[tgt_idx]  <= miss_page;
      ent_last[tgt_idx]  <= miss_off;
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == tgt_idx) begin
          ent_age[i] <= '0;
        end else if (ent_age[i] < ent_age[tgt_idx]) begin
          ent_age[i] <= ent_age[i] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spf_queue.sv
module spf_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic                       head_valid,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             do_pop;

  assign do_pop     = pop && (level != '0);
  assign head_valid = (level != '0);
  assign head_data  = mem[rd_ptr];

  // Storage carries no reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spf_sat_counter.sv
module spf_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import spf_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int ENTRIES    = DEF_ENTRIES,
  parameter int PAGE_BITS  = DEF_PAGE_BITS,
  parameter int BLOCK_BITS = DEF_BLOCK_BITS,
  parameter int NEAR_LIMIT = DEF_NEAR_LIMIT,
  parameter int QDEPTH     = DEF_QDEPTH,
  parameter int CNT_W      = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [CNT_W-1:0]  drop_count
);

  localparam int LVL_W = $clog2(QDEPTH+1);

  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [LVL_W-1:0]  q_level;
  logic              q_room;
  logic              q_push;
  logic              q_drop;

  spf_tracker #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS),
    .BLOCK_BITS(BLOCK_BITS), .NEAR_LIMIT(NEAR_LIMIT)
  ) u_track (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .req_valid(req_valid), .req_addr(req_addr)
  );

  // A full queue still has room when its head leaves in the same cycle
  assign q_room = (q_level != LVL_W'(QDEPTH)) || (pf_valid && pf_ready);
  assign q_push = req_valid && q_room;
  assign q_drop = req_valid && !q_room;

  spf_queue #(.W(ADDR_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(q_push), .push_data(req_addr),
    .pop(pf_ready),
    .head_valid(pf_valid), .head_data(pf_addr),
    .level(q_level)
  );

  spf_sat_counter #(.W(CNT_W)) u_drops (
    .clk(clk), .rst(rst), .inc(q_drop), .count(drop_count)
  );

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int BLOCK_BITS = 6,
  parameter int QDEPTH     = 4,
  parameter int CNT_W      = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       pf_valid,
  input logic                       pf_ready,
  input logic [ADDR_W-1:0]          pf_addr,
  input logic [CNT_W-1:0]           drop_count,
  input logic [$clog2(QDEPTH+1)-1:0] q_level
);

  localparam int LVL_W = $clog2(QDEPTH+1);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pf_valid && drop_count == '0));

  assert_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[BLOCK_BITS-1:0] == '0));

  assert_no_cross_R5: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[PAGE_BITS-1:BLOCK_BITS] != '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    q_level <= LVL_W'(QDEPTH));

  assert_drop_step_R8: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |->
      (drop_count == CNT_W'($past(drop_count) + 1'b1) &&
       $past(q_level) == LVL_W'(QDEPTH)));

endmodule

bind stream_prefetcher spf_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .BLOCK_BITS(BLOCK_BITS),
  .QDEPTH(QDEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_addr(pf_addr), .drop_count(drop_count), .q_level(q_level)
);

// File: tb/sim_stream_prefetcher.sv
module sim_stream_prefetcher;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;
  logic [15:0] drop_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prefetcher u0 (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .drop_count(drop_count)
  );

  // {miss address, request expected, expected request address, requirement}
  localparam logic [68:0] VEC [NV] = '{
    {32'h0001_0000, 1'b0, 32'h0, 4'd2},         // R2 new page
    {32'h0001_0040, 1'b1, 32'h0001_0080, 4'd3}, // R3 second near miss
    {32'h0001_0080, 1'b1, 32'h0001_00C0, 4'd3}, // R3 stream continues
    {32'h0001_0400, 1'b0, 32'h0, 4'd4},         // R4 far jump
    {32'h0001_0500, 1'b0, 32'h0, 4'd4},         // R4 exactly 256 apart
    {32'h0001_05C0, 1'b1, 32'h0001_0600, 4'd4}, // R4 measured from far miss
    {32'h0002_0FC0, 1'b0, 32'h0, 4'd2},         // R2 new page
    {32'h0002_0F80, 1'b1, 32'h0002_0FC0, 4'd3}, // R3 backward near
    {32'h0002_0FC0, 1'b0, 32'h0, 4'd5},         // R5 last block of page
    {32'h0001_0600, 1'b1, 32'h0001_0640, 4'd6}, // R6 two streams kept
    {32'h0003_0000, 1'b0, 32'h0, 4'd6},
    {32'h0004_0000, 1'b0, 32'h0, 4'd6},
    {32'h0005_0000, 1'b0, 32'h0, 4'd6},
    {32'h0006_0000, 1'b0, 32'h0, 4'd6},
    {32'h0007_0000, 1'b0, 32'h0, 4'd6},
    {32'h0008_0000, 1'b0, 32'h0, 4'd6},
    {32'h0009_0000, 1'b0, 32'h0, 4'd6},         // R6 replaces page 2
    {32'h0002_0F40, 1'b0, 32'h0, 4'd6},         // R6 page 2 forgotten
    {32'h0003_0040, 1'b1, 32'h0003_0080, 4'd6}, // R6 page 3 survived
    {32'h0001_0640, 1'b0, 32'h0, 4'd6}          // R6 page 1 forgotten
  };

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!pf_valid && drop_count == 16'd0, "R1 reset outputs",
          {pf_valid, 16'h0, drop_count}, 33'h0);

    // Table walk, consumer always ready
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = VEC[i][68:37];
      @(negedge clk);
      miss_valid = 1'b0;
      if (VEC[i][36])
        check(pf_valid && pf_addr == VEC[i][35:4],
              $sformatf("R%0d vector %0d", VEC[i][3:0], i),
              {pf_valid, pf_addr}, {1'b1, VEC[i][35:4]});
      else
        check(!pf_valid, $sformatf("R%0d vector %0d", VEC[i][3:0], i),
              {pf_valid, pf_addr}, 33'h0);
    end

    // Fill queue with the consumer stalled
    pf_ready = 1'b0;
    send_miss(32'h000A_0000);
    send_miss(32'h000A_0040);
    check(pf_valid && pf_addr == 32'h000A_0080, "R7 head while stalled",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_0080});
    send_miss(32'h000A_0080);
    send_miss(32'h000A_00C0);
    send_miss(32'h000A_0100);
    check(drop_count == 16'd0, "R8 no drop with four queued",
          {17'h0, drop_count}, 33'h0);
    send_miss(32'h000A_0140);
    check(drop_count == 16'd1, "R8 fifth request dropped",
          {17'h0, drop_count}, 33'h1);
    check(pf_valid && pf_addr == 32'h000A_0080, "R7 head held",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_0080});

    // Push and pop in the same cycle on a full queue
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = 32'h000A_0180;
    pf_ready   = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    check(drop_count == 16'd1, "R9 no drop when head leaves",
          {17'h0, drop_count}, 33'h1);
    check(pf_valid && pf_addr == 32'h000A_00C0, "R7 order 2",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_00C0});
    @(negedge clk);
    check(pf_valid && pf_addr == 32'h000A_0100, "R7 order 3",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_0100});
    @(negedge clk);
    check(pf_valid && pf_addr == 32'h000A_0140, "R7 order 4",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_0140});
    @(negedge clk);
    check(pf_valid && pf_addr == 32'h000A_01C0, "R9 same-cycle request kept",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_01C0});
    @(negedge clk);
    check(!pf_valid, "R7 queue drained", {pf_valid, pf_addr}, 33'h0);

    // Reset clears the table and the drop count
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(!pf_valid && drop_count == 16'd0, "R1 outputs after second reset",
          {pf_valid, 16'h0, drop_count}, 33'h0);
    send_miss(32'h000A_01C0);
    check(!pf_valid, "R1 table emptied by reset", {pf_valid, pf_addr}, 33'h0);
    send_miss(32'h000A_0200);
    check(pf_valid && pf_addr == 32'h000A_0240, "R3 stream after reset",
          {pf_valid, pf_addr}, {1'b1, 32'h000A_0240});

    repeat (2) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

endmodule